// File: doc/BRIEF.md
# Synchronous Serial Master with FIFOs

This block is a register-programmed serial master that moves frames of 4 to 16 bits over a four-wire synchronous link. Software fills an 8-entry transmit queue through a data register. The block shifts each entry out MSB first on `mosi` while it collects the same number of bits from `miso` (or, in loopback, from its own output). Each received frame goes into an 8-entry receive queue, which software empties by reading the same data register.

The bit clock comes from two dividers in series. One is an even prescaler and the other is a rate factor. Clock polarity and phase can be chosen freely, which gives all four clock modes. Four interrupt sources report queue levels, a receive overrun and a receive timeout. Each source has a raw view, a mask and a masked view, and the masked view is ORed onto a single `irq` line. Chip select is not part of the block; an external general-purpose output drives it.

Register word addresses on `bus_addr`:

| Address | Register |
|---|---|
| 0 | data |
| 1 | status |
| 2 | frame control |
| 3 | port control |
| 4 | prescale |
| 5 | interrupt mask |
| 6 | raw interrupts |
| 7 | masked interrupts |
| 8 | interrupt clear |

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, the status register (address 1) reads 0x03, the raw interrupt register (address 6) reads 0x08, the masked register (address 7) reads 0, and `irq`, `sclk` and `mosi` are low.
- R2: The `sclk` period is P×(1+S) clock cycles. P is the prescale register (address 4, bits 7:0), whose bit 0 always reads back 0. S is bits 15:8 of frame control (address 2).
- R3: Frame control bits 3:0 hold the frame length minus one; codes 3 to 15 give frames of 4 to 16 bits. With loopback (port control bit 0) set, each received frame equals the transmitted frame, taken from the low bits of the written word.
- R4: Frame control bit 6 sets the idle level of `sclk`, and bit 7 chooses the edge on which data is sampled. When bit 7 is 0, data is sampled on the first edge of each bit. When bit 7 is 1, data is sampled on the second edge. `mosi` carries the frame MSB first and is stable at every sampling edge.
- R5: With loopback clear, the receive data comes from `miso`.
- R6: A write to the data register (address 0) pushes bits 15:0 onto the transmit queue, and a write to a full queue is discarded. Status bit 0 means transmit queue empty and status bit 1 means transmit queue not full.
- R7: A read of the data register pops the receive queue and returns 0 when the queue is empty. Status bit 2 means receive queue not empty and status bit 3 means receive queue full.
- R8: A frame that completes while the receive queue is full is dropped, and raw interrupt bit 0 (overrun) is set. Writing 1 to bit 0 of the clear register (address 8) clears it.
- R9: Raw bit 1 (timeout) is set when the receive queue has been non-empty and unread for 32 `sclk` periods. Writing 1 to bit 1 of the clear register clears it.
- R10: Raw bit 3 is 1 while the transmit queue holds at most 4 entries. Raw bit 2 is 1 while the receive queue holds at least 4 entries.
- R11: The mask register (address 5) uses the same bit layout as the raw register. The masked register equals raw AND mask, and `irq` is the OR of the masked bits.
- R12: Frames shift only while port control bit 1 (enable) is 1, bit 2 (slave select) is 0, and frame control bits 5:4 are 00. Clearing enable aborts the current frame, returns `sclk` to its idle level and leaves queued entries in place. Status bit 4 (busy) is 1 while a frame shifts or the transmit queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive queue at data address) |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| sclk | output | 1 | Serial bit clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | OR of masked interrupt sources |

## Verification
The assertions assume three things about the inputs. Software changes clock polarity only while shifting is stopped. Read and write strobes never arrive in the same cycle. Configuration is written before the port is enabled. The stimulus meets these by rewriting frame control and prescale only after it has cleared the enable bit, and by issuing one bus access at a time from a single task. The `miso` pin follows the inverse of `mosi`, so any received frame taken from the pin is told apart from one taken from the internal loopback.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int FRAME_MAX = 16;
    localparam int EDGE_W    = $clog2(2 * FRAME_MAX + 1);

    typedef enum logic [3:0] {
        REG_DATA  = 4'd0,
        REG_STAT  = 4'd1,
        REG_FRAME = 4'd2,
        REG_PORT  = 4'd3,
        REG_PRE   = 4'd4,
        REG_IMASK = 4'd5,
        REG_IRAW  = 4'd6,
        REG_IMSK  = 4'd7,
        REG_ICLR  = 4'd8
    } reg_idx_e;

    typedef struct packed {
        logic                 active;
        logic [EDGE_W-1:0]    edges;
        logic [FRAME_MAX-1:0] tx_sh;
        logic [FRAME_MAX-1:0] rx_sh;
        logic                 sclk;
        logic                 mosi;
        logic [6:0]           pre_cnt;
        logic [7:0]           div_cnt;
    } shift_st_t;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [W-1:0]   wdata,
    input  logic           pop,
    output logic [W-1:0]   rdata,
    output logic [$clog2(DEPTH):0] level,
    output logic           full,
    output logic           empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
    } ptr_t;

    ptr_t           p_d, p_q;
    logic [W-1:0]   mem [DEPTH];
    logic           do_push, do_pop;

    assign level   = p_q.wp - p_q.rp;
    assign full    = (level == DEPTH_V);
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : mem[p_q.rp[AW-1:0]];

    always_comb begin
        p_d = p_q;
        if (do_push) p_d.wp = p_q.wp + 1'b1;
        if (do_pop)  p_d.rp = p_q.rp + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[p_q.wp[AW-1:0]] <= wdata;
    end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 cpol,
    input  logic                 cpha,
    input  logic                 lb,
    input  logic [3:0]           dss,
    input  logic [6:0]           pre_max,
    input  logic [7:0]           scr,
    input  logic                 miso,
    input  logic                 tx_avail,
    input  logic [FRAME_MAX-1:0] tx_word,
    output logic                 tx_take,
    output logic                 rx_done,
    output logic [FRAME_MAX-1:0] rx_word,
    output logic                 half_tick,
    output logic                 active,
    output logic                 sclk,
    output logic                 mosi
);
    shift_st_t            s_d, s_q;
    logic [EDGE_W-1:0]    last_edge;
    logic [EDGE_W-1:0]    nxt_edges;
    logic [FRAME_MAX-1:0] shifted;
    logic                 leading;
    logic                 sample_in;

    assign last_edge = EDGE_W'({dss, 1'b0}) + EDGE_W'(2);
    assign half_tick = run && (s_q.pre_cnt == pre_max) && (s_q.div_cnt == scr);
    assign sample_in = lb ? s_q.mosi : miso;
    assign nxt_edges = s_q.edges + 1'b1;
    assign shifted   = s_q.tx_sh << 1;
    assign leading   = ~s_q.edges[0];

    always_comb begin
        s_d     = s_q;
        tx_take = 1'b0;
        rx_done = 1'b0;
        if (!run) begin
            s_d.active  = 1'b0;
            s_d.edges   = '0;
            s_d.sclk    = cpol;
            s_d.pre_cnt = '0;
            s_d.div_cnt = '0;
        end else begin
            if (half_tick) begin
                s_d.pre_cnt = '0;
                s_d.div_cnt = '0;
            end else if (s_q.pre_cnt == pre_max) begin
                s_d.pre_cnt = '0;
                s_d.div_cnt = s_q.div_cnt + 1'b1;
            end else begin
                s_d.pre_cnt = s_q.pre_cnt + 1'b1;
            end

            if (!s_q.active) begin
                s_d.sclk = cpol;
                if (tx_avail) begin
                    tx_take     = 1'b1;
                    s_d.active  = 1'b1;
                    s_d.edges   = '0;
                    s_d.tx_sh   = tx_word;
                    s_d.rx_sh   = '0;
                    s_d.pre_cnt = '0;
                    s_d.div_cnt = '0;
                    if (!cpha) s_d.mosi = tx_word[dss];
                end
            end else if (half_tick) begin
                s_d.sclk  = ~s_q.sclk;
                s_d.edges = nxt_edges;
                if (leading ^ cpha) begin
                    s_d.rx_sh = {s_q.rx_sh[FRAME_MAX-2:0], sample_in};
                end else if (cpha) begin
                    s_d.mosi  = s_q.tx_sh[dss];
                    s_d.tx_sh = shifted;
                end else if (nxt_edges != last_edge) begin
                    s_d.mosi  = shifted[dss];
                    s_d.tx_sh = shifted;
                end
                if (nxt_edges == last_edge) begin
                    s_d.active = 1'b0;
                    rx_done    = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rx_word = s_d.rx_sh;
    assign active  = s_q.active;
    assign sclk    = s_q.sclk;
    assign mosi    = s_q.mosi;
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH  = 8,
    parameter int TMO_PERIODS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        irq
);
    localparam int LW = $clog2(FIFO_DEPTH) + 1;
    localparam logic [LW-1:0] HALF = LW'(FIFO_DEPTH / 2);
    localparam int TW = $clog2(2 * TMO_PERIODS + 1);
    localparam logic [TW-1:0] TMO_LIM = TW'(2 * TMO_PERIODS);

    typedef struct packed {
        logic [15:0]   frame;
        logic [3:0]    port;
        logic [7:0]    pre;
        logic [3:0]    imask;
        logic          ror;
        logic          rt;
        logic [TW-1:0] tmo_cnt;
    } regs_t;

    regs_t r_d, r_q;

    logic                 cpha, cpol, lb, run;
    logic [3:0]           dss;
    logic [6:0]           pre_max, pre_half;
    logic                 tx_push, tx_pop, tx_full, tx_empty;
    logic                 rx_push, rx_pop, rx_full, rx_empty;
    logic [LW-1:0]        tx_level, rx_level;
    logic [FRAME_MAX-1:0] tx_head, rx_head, rx_word;
    logic                 rx_done, half_tick, sh_active, busy;
    logic [3:0]           raw, masked;
    logic [4:0]           status;
    logic                 wr_data, wr_clr;

    assign cpha     = r_q.frame[7];
    assign cpol     = r_q.frame[6];
    assign dss      = (r_q.frame[3:0] < 4'd3) ? 4'd3 : r_q.frame[3:0];
    assign lb       = r_q.port[0];
    assign run      = r_q.port[1] && !r_q.port[2] && (r_q.frame[5:4] == 2'b00);
    assign pre_half = (r_q.pre[7:1] == 7'd0) ? 7'd1 : r_q.pre[7:1];
    assign pre_max  = pre_half - 7'd1;

    assign wr_data  = bus_wr && (bus_addr == REG_DATA);
    assign wr_clr   = bus_wr && (bus_addr == REG_ICLR);
    assign tx_push  = wr_data;
    assign rx_pop   = bus_rd && (bus_addr == REG_DATA);
    assign rx_push  = rx_done && !rx_full;

    spim_fifo #(.W(FRAME_MAX), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata[FRAME_MAX-1:0]),
        .pop(tx_pop), .rdata(tx_head), .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(FRAME_MAX), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_head), .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    spim_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .run(run), .cpol(cpol), .cpha(cpha), .lb(lb),
        .dss(dss), .pre_max(pre_max), .scr(r_q.frame[15:8]), .miso(miso),
        .tx_avail(!tx_empty), .tx_word(tx_head), .tx_take(tx_pop), .rx_done(rx_done),
        .rx_word(rx_word), .half_tick(half_tick), .active(sh_active),
        .sclk(sclk), .mosi(mosi)
    );

    assign busy   = sh_active || !tx_empty;
    assign status = {busy, rx_full, !rx_empty, !tx_full, tx_empty};
    assign raw    = {(tx_level <= HALF), (rx_level >= HALF), r_q.rt, r_q.ror};
    assign masked = raw & r_q.imask;
    assign irq    = |masked;

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            case (bus_addr)
                REG_FRAME: r_d.frame = bus_wdata[15:0];
                REG_PORT:  r_d.port  = bus_wdata[3:0];
                REG_PRE:   r_d.pre   = {bus_wdata[7:1], 1'b0};
                REG_IMASK: r_d.imask = bus_wdata[3:0];
                default: ;
            endcase
        end
        if (wr_clr && bus_wdata[0]) r_d.ror = 1'b0;
        if (wr_clr && bus_wdata[1]) r_d.rt  = 1'b0;
        if (rx_done && rx_full)     r_d.ror = 1'b1;

        if (rx_empty || rx_pop) begin
            r_d.tmo_cnt = '0;
        end else if (half_tick && (r_q.tmo_cnt != TMO_LIM)) begin
            r_d.tmo_cnt = r_q.tmo_cnt + 1'b1;
            if (r_d.tmo_cnt == TMO_LIM) r_d.rt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_DATA:  bus_rdata = {16'd0, rx_head};
            REG_STAT:  bus_rdata = {27'd0, status};
            REG_FRAME: bus_rdata = {16'd0, r_q.frame};
            REG_PORT:  bus_rdata = {28'd0, r_q.port};
            REG_PRE:   bus_rdata = {24'd0, r_q.pre};
            REG_IMASK: bus_rdata = {28'd0, r_q.imask};
            REG_IRAW:  bus_rdata = {28'd0, raw};
            REG_IMSK:  bus_rdata = {28'd0, masked};
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
    parameter int LW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          cpol,
    input logic          sclk,
    input logic          busy,
    input logic          shift_active,
    input logic          rx_full,
    input logic          rx_empty,
    input logic          rx_pop,
    input logic          tx_full,
    input logic          tx_pop,
    input logic [LW-1:0] tx_level,
    input logic          ror,
    input logic          rt
);
    // R12: stopped port holds the clock at its idle level
    assert_idle_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(!run) && $stable(cpol)) |-> (sclk == cpol));

    // R12: a shifting frame always reports busy
    assert_busy_shift_R12: assert property (@(posedge clk) disable iff (!rst_n)
        shift_active |-> busy);

    // R8: overrun only rises after a completion met a full receive queue
    assert_ror_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ror) |-> $past(rx_full));

    // R8: a full receive queue stays full until it is read
    assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rx_pop) |=> rx_full);

    // R9: timeout only rises while data waits in the receive queue
    assert_rt_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rt) |-> $past(!rx_empty));

    // R6: a write into a full transmit queue is discarded
    assert_tx_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && !tx_pop) |=> $stable(tx_level));
endmodule

bind spi_fifo_master spim_checker #(.LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .cpol(cpol), .sclk(sclk), .busy(busy),
    .shift_active(sh_active), .rx_full(rx_full), .rx_empty(rx_empty), .rx_pop(rx_pop),
    .tx_full(tx_full), .tx_pop(tx_pop), .tx_level(tx_level), .ror(r_q.ror), .rt(r_q.rt)
);

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, miso, irq;

    localparam logic [3:0] A_DATA = 4'd0, A_STAT = 4'd1, A_FRAME = 4'd2, A_PORT = 4'd3,
                           A_PRE = 4'd4, A_MASK = 4'd5, A_RAW = 4'd6, A_MSK = 4'd7,
                           A_CLR = 4'd8;

    int checks = 0, errors = 0, cyc = 0;
    logic [15:0] exp_tx[$];
    logic [15:0] exp_rx[$];
    logic        mon_on = 1'b0, mon_cpol = 1'b0, mon_cpha = 1'b0, cur_lb = 1'b0;
    int          mon_n = 8, mon_cnt = 0;
    logic [15:0] mon_sh = 16'd0, cur_msk = 16'hFF;

    always #4 clk = ~clk;   // 8-unit period, 125 MHz
    always @(posedge clk) cyc <= cyc + 1;
    assign miso = ~mosi;

    spi_fifo_master u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
        .miso(miso), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic cfg(input logic pol, input logic pha, input logic [3:0] dss,
                       input logic lb, input logic [7:0] pre, input logic [7:0] scr,
                       input logic en);
        mon_on = 1'b0;
        bus_write(A_PORT, 32'd0);
        bus_write(A_FRAME, {16'd0, scr, pha, pol, 2'b00, dss});
        bus_write(A_PRE, {24'd0, pre});
        mon_cpol = pol; mon_cpha = pha; mon_n = int'(dss) + 1; mon_cnt = 0;
        cur_msk = 16'((32'd1 << mon_n) - 1); cur_lb = lb;
        mon_on = 1'b1;
        if (en) bus_write(A_PORT, {30'd0, 1'b1, lb});
    endtask

    task automatic send(input logic [15:0] w, input logic keep_rx);
        exp_tx.push_back(w & cur_msk);
        if (keep_rx) exp_rx.push_back(cur_lb ? (w & cur_msk) : (~w & cur_msk));
        bus_write(A_DATA, {16'd0, w});
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            bus_read(A_STAT, v);
            if (!v[4]) break;
        end
    endtask

    task automatic drain(input int n, input string tag);
        logic [31:0] v;
        for (int i = 0; i < n; i++) begin
            bus_read(A_DATA, v);
            if (exp_rx.size() == 0) chk({tag, " queue"}, v, 32'hDEAD);
            else chk(tag, v, {16'd0, exp_rx.pop_front()});
        end
    endtask

    // monitor: collect mosi at each sampling edge and compare with the scoreboard
    always @(sclk) begin
        if (mon_on && rst_n && (sclk === (mon_cpol == mon_cpha))) begin
            mon_sh = {mon_sh[14:0], mosi};
            mon_cnt++;
            if (mon_cnt == mon_n) begin
                mon_cnt = 0;
                if (exp_tx.size() == 0) chk("R4 wire frame unexpected", {16'd0, mon_sh}, 32'hDEAD);
                else chk("R4 wire frame", {16'd0, mon_sh & cur_msk}, {16'd0, exp_tx.pop_front()});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int t0, t1, toggles;
        logic last;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(A_STAT, v); chk("R1 status", v, 32'h03);
        bus_read(A_RAW, v);  chk("R1 raw", v, 32'h08);
        bus_read(A_MSK, v);  chk("R1 masked", v, 32'h0);
        chk("R1 pins", {29'd0, irq, sclk, mosi}, 32'd0);

        // R2 prescale even
        bus_write(A_PRE, 32'd5);
        bus_read(A_PRE, v); chk("R2 prescale even", v, 32'd4);

        // R3/R4 mode 0, 8-bit loopback
        cfg(1'b0, 1'b0, 4'd7, 1'b1, 8'd2, 8'd0, 1'b1);
        send(16'h00A5, 1'b1); send(16'h003C, 1'b1); send(16'h01FF, 1'b1);
        wait_idle(); drain(3, "R3 loopback 8-bit");

        // R2 period measurement
        cfg(1'b0, 1'b0, 4'd7, 1'b1, 8'd4, 8'd2, 1'b1);
        send(16'h0081, 1'b1);
        @(posedge sclk); t0 = cyc; @(posedge sclk); t1 = cyc;
        chk("R2 period 4x3", t1 - t0, 12);
        wait_idle(); drain(1, "R3 loopback slow");
        cfg(1'b0, 1'b0, 4'd7, 1'b1, 8'd6, 8'd0, 1'b1);
        send(16'h0042, 1'b1);
        @(posedge sclk); t0 = cyc; @(posedge sclk); t1 = cyc;
        chk("R2 period 6x1", t1 - t0, 6);
        wait_idle(); drain(1, "R3 loopback 6");

        // R4 other modes and frame sizes
        cfg(1'b0, 1'b1, 4'd3, 1'b1, 8'd2, 8'd1, 1'b1);
        send(16'h000A, 1'b1); send(16'h0035, 1'b1);
        wait_idle(); drain(2, "R3 mode1 4-bit");
        cfg(1'b1, 1'b0, 4'd11, 1'b1, 8'd2, 8'd0, 1'b1);
        repeat (2) @(negedge clk);
        chk("R4 idle high", {31'd0, sclk}, 32'd1);
        send(16'h0ABC, 1'b1); send(16'h8123, 1'b1);
        wait_idle(); drain(2, "R3 mode2 12-bit");
        cfg(1'b1, 1'b1, 4'd15, 1'b1, 8'd2, 8'd0, 1'b1);
        send(16'hBEEF, 1'b1); send(16'h8001, 1'b1);
        wait_idle(); drain(2, "R3 mode3 16-bit");

        // R5 pin receive (miso = ~mosi)
        cfg(1'b0, 1'b0, 4'd15, 1'b0, 8'd2, 8'd0, 1'b1);
        send(16'h1234, 1'b1); send(16'hF00F, 1'b1);
        wait_idle(); drain(2, "R5 miso path");

        // R6/R10/R12 fill while disabled
        bus_write(A_CLR, 32'h3);
        cfg(1'b0, 1'b1, 4'd7, 1'b1, 8'd2, 8'd0, 1'b0);
        for (int i = 0; i < 4; i++) send(16'(8'h10 + i), 1'b1);
        bus_read(A_RAW, v); chk("R10 tx level 4", {31'd0, v[3]}, 32'd1);
        send(16'h0014, 1'b1);
        bus_read(A_RAW, v); chk("R10 tx level 5", {31'd0, v[3]}, 32'd0);
        for (int i = 5; i < 8; i++) send(16'(8'h10 + i), 1'b1);
        bus_write(A_DATA, 32'h00EE);   // ninth write, discarded
        bus_read(A_STAT, v); chk("R6 tx full busy", v, 32'h10);
        repeat (40) @(negedge clk);
        chk("R12 no clock while off", {31'd0, sclk}, 32'd0);
        bus_read(A_STAT, v); chk("R12 queue kept", v, 32'h10);
        bus_write(A_PORT, 32'h3);
        wait_idle();
        bus_read(A_STAT, v); chk("R7 rx full flags", v, 32'h0F);
        bus_read(A_RAW, v);  chk("R10 levels", v & 32'hD, 32'hC);
        bus_write(A_MASK, 32'h4);
        chk("R11 irq on rx", {31'd0, irq}, 32'd1);
        bus_read(A_MSK, v);  chk("R11 masked rx", v, 32'h4);

        // R8 overrun
        send(16'h0077, 1'b0);
        wait_idle();
        bus_read(A_RAW, v); chk("R8 overrun set", {31'd0, v[0]}, 32'd1);
        bus_write(A_MASK, 32'h1);
        bus_read(A_MSK, v); chk("R11 masked ror", v, 32'h1);
        bus_write(A_CLR, 32'h1);
        bus_read(A_RAW, v); chk("R8 overrun cleared", {31'd0, v[0]}, 32'd0);
        bus_write(A_MASK, 32'h0);
        chk("R11 irq masked off", {31'd0, irq}, 32'd0);
        drain(4, "R8 kept frames");
        bus_read(A_RAW, v); chk("R10 rx level 4", {31'd0, v[2]}, 32'd1);
        drain(1, "R8 kept frames");
        bus_read(A_RAW, v); chk("R10 rx level 3", {31'd0, v[2]}, 32'd0);
        drain(3, "R8 kept frames");
        bus_read(A_DATA, v); chk("R7 empty read", v, 32'd0);
        bus_read(A_STAT, v); chk("R7 empty status", v, 32'h03);

        // R9 timeout
        bus_write(A_CLR, 32'h3);
        cfg(1'b0, 1'b0, 4'd7, 1'b1, 8'd2, 8'd0, 1'b1);
        send(16'h005A, 1'b1);
        wait_idle();
        bus_read(A_RAW, v); chk("R9 not yet", {31'd0, v[1]}, 32'd0);
        repeat (200) @(negedge clk);
        bus_read(A_RAW, v); chk("R9 timeout set", {31'd0, v[1]}, 32'd1);
        bus_write(A_MASK, 32'h2);
        chk("R11 irq timeout", {31'd0, irq}, 32'd1);
        bus_write(A_CLR, 32'h2);
        bus_read(A_RAW, v); chk("R9 timeout cleared", {31'd0, v[1]}, 32'd0);
        bus_write(A_MASK, 32'h0);
        drain(1, "R9 frame");

        // R12 abort mid-frame
        cfg(1'b1, 1'b0, 4'd15, 1'b1, 8'd8, 8'd7, 1'b1);
        mon_on = 1'b0;
        bus_write(A_DATA, 32'h5555);
        repeat (50) @(negedge clk);
        bus_write(A_PORT, 32'h1);
        repeat (3) @(negedge clk);
        chk("R12 idle after abort", {31'd0, sclk}, 32'd1);
        toggles = 0; last = sclk;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sclk !== last) toggles++;
            last = sclk;
        end
        chk("R12 no edges after abort", toggles, 0);
        bus_read(A_STAT, v); chk("R12 aborted frame dropped", v, 32'h03);

        chk("R4 all frames seen", exp_tx.size(), 0);
        chk("R3 all frames received", exp_rx.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule